// File: doc/BRIEF.md
# Line Latch with Polarity Steering

This block sits after the capture stage of a column driver. It takes the full line register, which holds one gray code per output channel, and copies it into a holding latch once per horizontal period. The copy happens under a strobe that is sampled on the system clock. For every channel the block sends a gray code, a bank-select bit and a drive-enable bit to the converter stage. The bank-select bit picks the upper or the lower reference set. When the drive-enable bit is low, it stands for a floating, high-impedance output.

The strobe uses both of its edges:
- The clock edge that first sees the strobe high copies the line and latches the polarity input. The same edge floats every channel.
- The edge that first sees the strobe low again drives the channels with the new codes.

The latched polarity decides which channels get the upper bank: the odd-numbered ones or the even-numbered ones. Swapping this each line gives column or dot inversion on the panel. A sticky error flag catches two protocol faults: a strobe that is too short, and a polarity change while the polarity must be held.

Top module: `line_latch_steer`

## Requirements
- R1: At the clock edge where the strobe is sampled high after being sampled low, the whole line input is copied into the holding latch. The copied codes appear on `ch_code` after that edge.
- R2: From the clock after the strobe is first sampled high until the edge that sees it low again, `ch_drive` is all zeros (high impedance). From the edge that sees the strobe low after a high, every bit of `ch_drive` is 1.
- R3: Channels are numbered from 1, and channel n sits at index n-1. When the latched polarity is 0, odd-numbered channels have `ch_upper`=1 (upper bank) and even-numbered channels have 0. When the latched polarity is 1, the assignment is swapped.
- R4: The polarity is taken only at the strobe rising edge. Later changes of the polarity input leave `ch_upper` unchanged until the next strobe.
- R5: Between strobes, `ch_code` and `ch_upper` hold steady, even while `line_data` changes.
- R6: A strobe sampled high on fewer than 3 clock edges sets `proto_err` at the edge that sees it fall.
- R7: A change of `polarity` away from its latched value sets `proto_err` in either of two windows: while the strobe is high, or on the fall edge and the 3 edges after it. A change after that window does not set the flag.
- R8: `proto_err` stays at 1 once set, until reset.
- R9: After reset, `ch_drive` is all zeros, `ch_code` is zero and `proto_err` is 0. The outputs stay floating until the first strobe falls.
- R10: The code for channel index i occupies bits [6i+5:6i] of `line_data` and of `ch_code`, with its LSB at bit 6i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_data | input | NUM_CH*CODE_W | Full line register from the capture stage |
| strobe | input | 1 | Line strobe: rise loads and floats, fall drives |
| polarity | input | 1 | Bank polarity for the next line |
| ch_code | output | NUM_CH*CODE_W | Latched gray code per channel |
| ch_upper | output | NUM_CH | 1 = upper reference bank, per channel |
| ch_drive | output | NUM_CH | 1 = channel driven, 0 = high impedance |
| proto_err | output | 1 | Sticky strobe-width or polarity-hold violation |

## Verification
The bench goes after these cases:
- **Strobe exactly at the minimum width and one clock short of it.** A wrong width counter would either flag legal lines or miss narrow ones.
- **A polarity change inside the hold window, and another just outside it.** An off-by-one guard counter would show up in one of the two.
- **`line_data` changing while the latch holds.** A latch enable left open would pass the capture stage's refills straight through to the channels.
- **Back-to-back lines with alternating polarity.** These expose wrong odd/even steering or a polarity sampled at the wrong edge.
- **The float window after reset.** This catches a block that drives before its first complete strobe.

// File: rtl/lls_pkg.sv
package lls_pkg;
  localparam int unsigned DEF_NUM_CH   = 384;
  localparam int unsigned DEF_CODE_W   = 6;
  localparam int unsigned DEF_MIN_WID  = 3;
  localparam int unsigned DEF_GUARD    = 3;

  // Channel index i is channel number i+1, so even indices are odd-numbered channels.
  function automatic logic odd_numbered(input int unsigned idx);
    return (idx % 2) == 0;
  endfunction
endpackage

// File: rtl/strobe_seq.sv
module strobe_seq #(
  parameter int unsigned MIN_WID = lls_pkg::DEF_MIN_WID,
  parameter int unsigned GUARD   = lls_pkg::DEF_GUARD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic polarity,
  output logic latch_en,
  output logic pol_q,
  output logic drive_q,
  output logic err_q
);
  localparam int unsigned WCW = $clog2(MIN_WID + 1);
  localparam int unsigned GCW = $clog2(GUARD + 1);
  localparam logic [WCW-1:0] WMAX = WCW'(MIN_WID);
  localparam logic [GCW-1:0] GLOAD = GCW'(GUARD);

  logic           stb_q;
  logic [WCW-1:0] wid_q, wid_d;
  logic [GCW-1:0] grd_q, grd_d;
  logic           pol_d, drive_d, err_d;
  logic           rise, fall, held, window, narrow, pol_bad;

  always_comb begin
    rise    = strobe & ~stb_q;
    fall    = ~strobe & stb_q;
    held    = strobe & stb_q;
    latch_en = rise;

    wid_d = wid_q;
    if (rise)                       wid_d = WCW'(1);
    else if (held && wid_q < WMAX)  wid_d = wid_q + WCW'(1);

    grd_d = grd_q;
    if (fall)                       grd_d = GLOAD;
    else if (grd_q != '0)           grd_d = grd_q - GCW'(1);

    window  = held | fall | (grd_q != '0);
    narrow  = fall & (wid_q < WMAX);
    pol_bad = window & (polarity != pol_q);
    err_d   = err_q | narrow | pol_bad;

    pol_d   = rise ? polarity : pol_q;

    drive_d = drive_q;
    if (rise)      drive_d = 1'b0;
    else if (fall) drive_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      wid_q   <= '0;
      grd_q   <= '0;
      pol_q   <= 1'b0;
      drive_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      stb_q   <= strobe;
      wid_q   <= wid_d;
      grd_q   <= grd_d;
      pol_q   <= pol_d;
      drive_q <= drive_d;
      err_q   <= err_d;
    end
  end
endmodule

// File: rtl/line_hold.sv
module line_hold #(
  parameter int unsigned NUM_CH = lls_pkg::DEF_NUM_CH,
  parameter int unsigned CODE_W = lls_pkg::DEF_CODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_en,
  input  logic [NUM_CH*CODE_W-1:0]   line_in,
  output logic [NUM_CH*CODE_W-1:0]   code_q
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      logic [CODE_W-1:0] slot_q, slot_d;
      always_comb slot_d = load_en ? line_in[gi*CODE_W +: CODE_W] : slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
      end
      assign code_q[gi*CODE_W +: CODE_W] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/bank_steer.sv
module bank_steer #(
  parameter int unsigned NUM_CH = lls_pkg::DEF_NUM_CH
) (
  input  logic              pol,
  output logic [NUM_CH-1:0] upper
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_bank
      localparam logic ODD_NUM = lls_pkg::odd_numbered(gi);
      assign upper[gi] = ODD_NUM ^ pol;
    end
  endgenerate
endmodule

// File: rtl/line_latch_steer.sv
module line_latch_steer #(
  parameter int unsigned NUM_CH  = lls_pkg::DEF_NUM_CH,
  parameter int unsigned CODE_W  = lls_pkg::DEF_CODE_W,
  parameter int unsigned MIN_WID = lls_pkg::DEF_MIN_WID,
  parameter int unsigned GUARD   = lls_pkg::DEF_GUARD
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH*CODE_W-1:0]  line_data,
  input  logic                      strobe,
  input  logic                      polarity,
  output logic [NUM_CH*CODE_W-1:0]  ch_code,
  output logic [NUM_CH-1:0]         ch_upper,
  output logic [NUM_CH-1:0]         ch_drive,
  output logic                      proto_err
);
  logic latch_en, pol_q, drive_q;

  strobe_seq #(.MIN_WID(MIN_WID), .GUARD(GUARD)) u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .polarity(polarity),
    .latch_en(latch_en), .pol_q(pol_q), .drive_q(drive_q), .err_q(proto_err)
  );

  line_hold #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_en(latch_en),
    .line_in(line_data), .code_q(ch_code)
  );

  bank_steer #(.NUM_CH(NUM_CH)) u_steer (
    .pol(pol_q), .upper(ch_upper)
  );

  assign ch_drive = {NUM_CH{drive_q}};
endmodule

// File: rtl/line_latch_steer_chk.sv
module line_latch_steer_chk #(
  parameter int unsigned NUM_CH = lls_pkg::DEF_NUM_CH,
  parameter int unsigned CODE_W = lls_pkg::DEF_CODE_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_CH*CODE_W-1:0]  line_data,
  input logic                      strobe,
  input logic                      polarity,
  input logic [NUM_CH*CODE_W-1:0]  ch_code,
  input logic [NUM_CH-1:0]         ch_upper,
  input logic [NUM_CH-1:0]         ch_drive,
  input logic                      proto_err
);
  // R1
  load_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !$past(strobe)) |=> (ch_code == $past(line_data)));
  // R2
  float_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (ch_drive == '0));
  // R2
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && $past(strobe)) |=> (ch_drive == '1));
  // R3
  odd_even_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_upper[0] != ch_upper[1]);
  // R3
  pol_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !$past(strobe)) |=> (ch_upper[0] == !$past(polarity)));
  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(ch_code));
  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(ch_upper));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind line_latch_steer line_latch_steer_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_data(line_data), .strobe(strobe),
  .polarity(polarity), .ch_code(ch_code), .ch_upper(ch_upper),
  .ch_drive(ch_drive), .proto_err(proto_err)
);

// File: tb/line_latch_steer_tb.sv
module line_latch_steer_tb;
  localparam int N = 384;
  localparam int CW = 6;
  localparam int W = N * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] line_data = '0;
  logic strobe = 1'b0;
  logic polarity = 1'b0;
  logic [W-1:0] ch_code;
  logic [N-1:0] ch_upper, ch_drive;
  logic proto_err;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct { logic [W-1:0] code; logic [N-1:0] upper; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  line_latch_steer u_dut (
    .clk(clk), .rst_n(rst_n), .line_data(line_data), .strobe(strobe),
    .polarity(polarity), .ch_code(ch_code), .ch_upper(ch_upper),
    .ch_drive(ch_drive), .proto_err(proto_err)
  );

  function automatic logic [W-1:0] mk_line(input int seed);
    logic [W-1:0] v;
    for (int i = 0; i < N; i++) v[i*CW +: CW] = CW'((i * seed + seed * 7) % 64);
    return v;
  endfunction

  function automatic logic [N-1:0] mk_upper(input logic pol);
    logic [N-1:0] u;
    for (int i = 0; i < N; i++) u[i] = ((i % 2) == 0) ^ pol;
    return u;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one line with a strobe of given width; pushes the expected result.
  task automatic run_line(input int seed, input logic pol, input int width);
    exp_t e;
    line_data = mk_line(seed);
    polarity = pol;
    @(negedge clk);
    strobe = 1'b1;
    e.code = mk_line(seed);
    e.upper = mk_upper(pol);
    sb.push_back(e);
    @(negedge clk);
    chk("R2 float during strobe", 64'(ch_drive == '0), 64'd1);
    repeat (width - 1) @(negedge clk);
    strobe = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // Monitor: compare each newly driven line with the scoreboard.
  initial begin
    logic prev = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && ch_drive[0] && !prev) begin
        if (sb.size() == 0) begin
          chk("R2 unexpected drive", 64'd1, 64'd0);
        end else begin
          e = sb.pop_front();
          chk("R1 latched codes", 64'(ch_code == e.code), 64'd1);
          chk("R3 bank steering", 64'(ch_upper == e.upper), 64'd1);
          chk("R2 all channels driven", 64'(ch_drive == '1), 64'd1);
        end
      end
      prev = ch_drive[0];
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] up_saved;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 drive after reset", 64'(ch_drive), 64'd0);
    chk("R9 code after reset", 64'(ch_code == '0), 64'd1);
    chk("R9 err after reset", 64'(proto_err), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 floating before first strobe", 64'(ch_drive == '0), 64'd1);

    run_line(1, 1'b0, 3);
    chk("R6 minimum width no error", 64'(proto_err), 64'd0);

    // R5: capture stage refills the line register between strobes
    line_data = mk_line(9);
    repeat (4) @(negedge clk);
    chk("R5 code hold during refill", 64'(ch_code == mk_line(1)), 64'd1);

    run_line(2, 1'b1, 5);
    up_saved = ch_upper;
    polarity = 1'b0;   // outside guard window
    repeat (3) @(negedge clk);
    chk("R4 upper unchanged by late polarity", 64'(ch_upper == up_saved), 64'd1);
    chk("R4 channel 1 lower when pol=1", 64'(ch_upper[0]), 64'd0);
    chk("R7 change outside window no error", 64'(proto_err), 64'd0);

    run_line(5, 1'b0, 4);
    // R10 field positions
    chk("R10 channel index 0 code", 64'(ch_code[5:0]), 64'd35);
    chk("R10 channel index 383 code", 64'(ch_code[W-1 -: CW]), 64'd30);
    chk("R3 channel 1 upper when pol=0", 64'(ch_upper[0]), 64'd1);

    // R6 narrow strobe
    run_line(3, 1'b1, 2);
    chk("R6 narrow strobe error", 64'(proto_err), 64'd1);
    run_line(4, 1'b0, 3);
    chk("R8 error sticky", 64'(proto_err), 64'd1);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 err cleared by reset", 64'(proto_err), 64'd0);
    chk("R9 float after reset", 64'(ch_drive == '0), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 polarity change one clock after fall
    line_data = mk_line(6);
    polarity = 1'b1;
    @(negedge clk);
    strobe = 1'b1;
    begin
      exp_t e;
      e.code = mk_line(6);
      e.upper = mk_upper(1'b1);
      sb.push_back(e);
    end
    repeat (3) @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    polarity = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 change inside window error", 64'(proto_err), 64'd1);
    chk("R4 upper kept after change", 64'(ch_upper[0]), 64'd0);

    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", 64'(sb.size()), 64'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule